// File: doc/BRIEF.md
# DC-Only 4x4 Pixel Reconstruction

This block is the shortcut reconstruction path for a 4x4 residual block whose only nonzero coefficient is the DC term. It takes no full inverse transform. The signed DC value passes through two scaling stages. Each stage multiplies by the fixed cosine constant 11585 and then rounds back down by 14 bits. A final rounding by 4 bits turns the result into a single signed offset. That one offset is then applied to all sixteen 8-bit prediction pixels. A positive offset is added and saturates at 255. A negative offset has its magnitude subtracted and saturates at 0.

A caller presents the DC value and the four packed prediction rows together with a one-cycle start pulse. The block captures both. It then emits the four corrected rows on four consecutive cycles. Each emitted row carries a valid flag and its row index. While those rows are being emitted, further start pulses are ignored. Detecting that only DC is present, and fetching or storing pixels, belong to the surrounding logic.

Top module: `dc4x4_recon`

## Requirements
- R1: While reset is asserted, and after it is released until the first accepted start, `row_valid_o` and `busy_o` are 0.
- R2: The first scaling stage computes `s1 = (dc * 11585 + 8192) >>> 14`, with an arithmetic shift on the signed 16-bit DC value.
- R3: The second stage computes `s2 = (s1 * 11585 + 8192) >>> 14`. The offset is `off = (s2 + 8) >>> 4`, again with an arithmetic shift.
- R4: When `off >= 0`, every output pixel is `min(pixel + off, 255)`.
- R5: When `off < 0`, every output pixel is `max(pixel - |off|, 0)`.
- R6: When `|off|` exceeds 255, every pixel clamps to 255 if the offset is positive and to 0 if it is negative.
- R7: A start pulse seen while idle captures `dc_i` and `rows_i`. On the next four clock edges the block emits rows 0, 1, 2 and 3 with `row_valid_o` high and `row_idx_o` equal to the row number. Row k is taken from `rows_i[32k+31:32k]`. `row_valid_o` is low on the edge after row 3.
- R8: A start pulse while `busy_o` is high has no effect on the rows being emitted. This includes any change of `dc_i` or `rows_i` at that time.
- R9: Within a row, pixel lane j sits at bits `[8j+7:8j]`. Each lane saturates independently of the other lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to reconstruct a block |
| dc_i | input | 16 | Signed DC coefficient |
| rows_i | input | 128 | Four prediction rows, row k at bits [32k+31:32k] |
| busy_o | output | 1 | High while captured rows remain to be emitted |
| row_valid_o | output | 1 | The outputs carry a reconstructed row |
| row_idx_o | output | 2 | Index of the emitted row |
| row_o | output | 32 | Reconstructed row, four packed 8-bit pixels |

## Verification
The sequencing assertions assume a single-cycle start pulse. They also assume that `start_i` is never X once reset is released. The lane assertions assume the magnitude fed to a lane has already been clamped to the pixel range. The stimulus drives every input only on the falling edge. It holds `dc_i` and `rows_i` stable around each accepted start. It then deliberately changes them during a busy window, where they must be ignored. The DC values cover zero, small values of both signs, and both extremes of the 16-bit range. The pixel patterns sit at 0, at 255 and in between.

// File: rtl/dc4x4_recon_pkg.sv
package dc4x4_recon_pkg;
  localparam int PIX_W    = 8;
  localparam int LANES    = 4;
  localparam int ROWS     = 4;
  localparam int DC_W     = 16;
  localparam int COS_K    = 11585;
  localparam int SCALE_SH = 14;
  localparam int FINAL_SH = 4;
  localparam int ROW_W    = PIX_W * LANES;
  localparam int PTR_W    = $clog2(ROWS);
  localparam int PIX_MAX  = (1 << PIX_W) - 1;

  // one scaling stage: multiply by the cosine constant, round, arithmetic shift
  function automatic logic signed [31:0] scale_round(input logic signed [31:0] v);
    logic signed [31:0] prod;
    prod = v * 32'(COS_K);
    return (prod + (32'sd1 <<< (SCALE_SH - 1))) >>> SCALE_SH;
  endfunction

  // full DC to offset path: two scaling stages then the final rounding
  function automatic logic signed [31:0] dc_to_offset(input logic signed [DC_W-1:0] dc);
    logic signed [31:0] st;
    st = scale_round(32'(dc));
    st = scale_round(st);
    return (st + (32'sd1 <<< (FINAL_SH - 1))) >>> FINAL_SH;
  endfunction

  // saturating lane update with a magnitude already clamped to the pixel range
  function automatic logic [PIX_W-1:0] lane_update(input logic [PIX_W-1:0] pix,
                                                   input logic [PIX_W-1:0] mag,
                                                   input logic             neg);
    logic [PIX_W:0] sum;
    if (neg) begin
      return (pix > mag) ? (pix - mag) : '0;
    end
    sum = {1'b0, pix} + {1'b0, mag};
    return sum[PIX_W] ? PIX_W'(PIX_MAX) : sum[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/dc_offset_calc.sv
module dc_offset_calc
  import dc4x4_recon_pkg::*;
(
  input  logic signed [DC_W-1:0] dc_i,
  output logic                   neg_o,
  output logic [PIX_W-1:0]       mag_o
);
  logic signed [31:0] offset_w;
  logic        [31:0] abs_w;

  always_comb begin
    offset_w = dc_to_offset(dc_i);
    neg_o    = offset_w[31];
    abs_w    = neg_o ? 32'(-offset_w) : 32'(offset_w);
    // R6: a magnitude beyond the pixel range saturates every lane
    mag_o    = (abs_w > 32'(PIX_MAX)) ? PIX_W'(PIX_MAX) : abs_w[PIX_W-1:0];
  end
endmodule

// File: rtl/lane_sat_unit.sv
module lane_sat_unit
  import dc4x4_recon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] pix_i,
  input  logic [PIX_W-1:0] mag_i,
  input  logic             neg_i,
  output logic [PIX_W-1:0] pix_o
);
  always_comb pix_o = lane_update(pix_i, mag_i, neg_i);

  // R4
  add_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !neg_i |-> (pix_o >= pix_i));
  // R5
  sub_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    neg_i |-> (pix_o <= pix_i));
endmodule

// File: rtl/row_sequencer.sv
module row_sequencer
  import dc4x4_recon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             accept_o,
  output logic             emit_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             busy_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ROWS - 1);

  logic             busy_q;
  logic [PTR_W-1:0] ptr_q;

  assign accept_o = start_i && !busy_q;
  assign emit_o   = busy_q;
  assign ptr_o    = ptr_q;
  assign busy_o   = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      ptr_q  <= '0;
    end else if (busy_q) begin
      ptr_q <= ptr_q + 1'b1;
      if (ptr_q == LAST) busy_q <= 1'b0;
    end
  end

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ptr_q != LAST) |=> busy_q);
endmodule

// File: rtl/dc4x4_recon.sv
module dc4x4_recon
  import dc4x4_recon_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic signed [DC_W-1:0]   dc_i,
  input  logic [ROWS*ROW_W-1:0]    rows_i,
  output logic                     busy_o,
  output logic                     row_valid_o,
  output logic [PTR_W-1:0]         row_idx_o,
  output logic [ROW_W-1:0]         row_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ROWS - 1);

  logic             accept_w, emit_w;
  logic [PTR_W-1:0] ptr_w;
  logic             neg_w;
  logic [PIX_W-1:0] mag_w;

  logic             neg_q;
  logic [PIX_W-1:0] mag_q;
  logic [ROW_W-1:0] rows_q [ROWS];
  logic [ROW_W-1:0] cur_row_w;
  logic [ROW_W-1:0] new_row_w;

  row_sequencer u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .accept_o (accept_w),
    .emit_o   (emit_w),
    .ptr_o    (ptr_w),
    .busy_o   (busy_o)
  );

  dc_offset_calc u_off (
    .dc_i  (dc_i),
    .neg_o (neg_w),
    .mag_o (mag_w)
  );

  // capture offset and prediction rows on an accepted start (R8: only then)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q <= 1'b0;
      mag_q <= '0;
    end else if (accept_w) begin
      neg_q <= neg_w;
      mag_q <= mag_w;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_rows
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rows_q[r] <= '0;
      else if (accept_w) rows_q[r] <= rows_i[r*ROW_W +: ROW_W];
    end
  end

  assign cur_row_w = rows_q[ptr_w];

  for (genvar j = 0; j < LANES; j++) begin : g_lanes
    lane_sat_unit u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .pix_i (cur_row_w[j*PIX_W +: PIX_W]),
      .mag_i (mag_q),
      .neg_i (neg_q),
      .pix_o (new_row_w[j*PIX_W +: PIX_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_valid_o <= 1'b0;
      row_idx_o   <= '0;
      row_o       <= '0;
    end else begin
      row_valid_o <= emit_w;
      if (emit_w) begin
        row_idx_o <= ptr_w;
        row_o     <= new_row_w;
      end
    end
  end

  // R7
  seq_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> ##1 (row_valid_o && row_idx_o == '0));
  // R7
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid_o && row_idx_o != LAST) |=> (row_valid_o && row_idx_o == $past(row_idx_o) + 1'b1));
  // R7
  seq_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid_o && row_idx_o == LAST) |=> !row_valid_o);
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> ($stable(neg_q) && $stable(mag_q)));
endmodule

// File: tb/dc4x4_recon_tb_top.sv
module dc4x4_recon_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [15:0]  dc_i = '0;
  logic [127:0] rows_i = '0;
  logic         busy_o, row_valid_o;
  logic [1:0]   row_idx_o;
  logic [31:0]  row_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  dc4x4_recon dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dc_i(dc_i), .rows_i(rows_i),
    .busy_o(busy_o), .row_valid_o(row_valid_o), .row_idx_o(row_idx_o), .row_o(row_o)
  );

  // floor division for the reference arithmetic (R2, R3)
  function automatic int fdiv(int a, int b);
    int q;
    q = a / b;
    if ((a % b != 0) && (a < 0)) q = q - 1;
    return q;
  endfunction

  function automatic int ref_offset(int dc);
    int s1, s2;
    s1 = fdiv(dc * 11585 + 8192, 16384);  // R2
    s2 = fdiv(s1 * 11585 + 8192, 16384);  // R3
    return fdiv(s2 + 8, 16);
  endfunction

  function automatic logic [31:0] ref_row(logic [31:0] pred, int off);
    logic [31:0] res;
    for (int j = 0; j < 4; j++) begin
      int v;
      v = int'(pred[8*j +: 8]) + off;  // R9 lane j at bits 8j+7:8j
      if (v > 255) v = 255;
      if (v < 0) v = 0;
      res[8*j +: 8] = 8'(v);
    end
    return res;
  endfunction

  // behavioural model, advanced on each rising edge
  logic [31:0] m_rows [$];
  int          m_off = 0;
  int          m_left = 0;
  int          m_idx = 0;
  logic        exp_valid = 1'b0;
  logic [1:0]  exp_idx = '0;
  logic [31:0] exp_row = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_valid = 1'b0;
      m_left = 0;
      m_rows.delete();
    end else if (m_left > 0) begin
      exp_valid = 1'b1;
      exp_idx   = 2'(m_idx);
      exp_row   = ref_row(m_rows.pop_front(), m_off);
      m_idx++;
      m_left--;
    end else begin
      exp_valid = 1'b0;
      if (start_i) begin
        m_off = ref_offset(int'($signed(dc_i)));
        for (int k = 0; k < 4; k++) m_rows.push_back(rows_i[32*k +: 32]);
        m_left = 4;
        m_idx = 0;
      end
    end
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      check(row_valid_o == 1'b0 && busy_o == 1'b0, "R1 reset state",
            {30'd0, busy_o, row_valid_o}, 32'd0);
    end else begin
      check(row_valid_o == exp_valid, "R7 valid timing", {31'd0, row_valid_o}, {31'd0, exp_valid});
      if (exp_valid && row_valid_o) begin
        check(row_idx_o == exp_idx, "R7 row index", {30'd0, row_idx_o}, {30'd0, exp_idx});
        if (m_off > 255 || m_off < -255)
          check(row_o == exp_row, "R6 clamped row", row_o, exp_row);
        else if (m_off < 0)
          check(row_o == exp_row, "R5 R9 subtract row", row_o, exp_row);
        else
          check(row_o == exp_row, "R4 R9 add row", row_o, exp_row);
      end
    end
  end

  task automatic run_block(logic [15:0] dc, logic [31:0] r0, logic [31:0] r1,
                           logic [31:0] r2, logic [31:0] r3);
    @(negedge clk);
    dc_i = dc;
    rows_i = {r3, r2, r1, r0};
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);  // R1 idle after release
    run_block(16'd0,     32'h00FF_7F01, 32'h1234_5678, 32'hFFFF_0000, 32'h8080_8080); // R2 R3 zero offset
    run_block(16'd16,    32'h00FF_7F01, 32'hFEFD_0102, 32'h10_20_30_40, 32'hFF00_FF00); // R4 small add
    run_block(16'd200,   32'hF0FA_FF05, 32'h0000_0000, 32'hE0E8_F0F8, 32'h0102_0304); // R4 R9 mixed clamp
    run_block(-16'sd200, 32'h0A05_0100, 32'hFFFF_FFFF, 32'h1018_0820, 32'h0000_00FF); // R5 R9
    run_block(-16'sd17,  32'h0001_0203, 32'h7F80_8182, 32'h0000_0000, 32'h0909_0909); // R5 rounding
    run_block(16'd32767, 32'h0000_0001, 32'h8080_8080, 32'h1234_5678, 32'hFFFF_FFFF); // R6 positive clamp
    run_block(-16'sd32768, 32'hFFFF_FFFF, 32'h8080_8080, 32'h0102_0304, 32'h0000_0000); // R6 negative clamp
    // R8: start while busy with new data must be ignored
    @(negedge clk);
    dc_i = 16'd400;
    rows_i = {32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444};
    start_i = 1'b1;
    @(negedge clk);
    dc_i = -16'sd3000;
    rows_i = {4{32'hAAAA_AAAA}};
    @(negedge clk);
    dc_i = 16'd5;
    @(negedge clk);
    start_i = 1'b0;
    repeat (8) @(negedge clk);
    run_block(16'd1000,  32'h0102_0304, 32'hFBFC_FDFE, 32'h8000_0080, 32'h5A5A_A5A5); // R4 R7 again
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected<5000", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule